// File: doc/BRIEF.md
# Time-of-Day Clock Core with Field Setting and Hourly Chime

The block keeps 24-hour time as three BCD digit pairs (hours, minutes, seconds), all clocked by one 1024 Hz reference. A divider inside the block makes the one-second count, the half-second blink phase and a 512 Hz square wave. All of these are clock enables or plain registers, so every flop in the block uses the one reference clock.

An operator sets the time by raising the adjust input. While adjust is active, each rising edge on the select input swaps the target between hours and minutes. Each rising edge on the increment input then advances the target by one. The digits of the target field blink on the outputs at 1 Hz. A tone output gives a short two-pitch chime just before each full hour. The six output digits feed a separate scanned display driver.

Top module: `clock_core`

## Requirements
- R1: The seconds value changes only once per 1024 reference cycles. After reset release, the seconds ones digit shows 0 after edge 1023 and 1 after edge 1024.
- R2: Seconds and minutes count 00..59 in BCD and return to 00 after 59. A seconds rollover advances minutes by one when minutes are not the field under adjustment.
- R3: Hours count 00..23 in BCD and return from 23 to 00, whether the step comes from a minute carry or from a manual increment.
- R4: The select input toggles the target field only while the synchronized adjust level is high. After reset the target is minutes (0); hours is 1.
- R5: In adjust mode each increment press advances only the target field, and that field ignores its normal carry. A manual rollover of the target produces no carry. The other fields keep their normal sources.
- R6: In adjust mode the digits of the target field pass through while the divider phase is in the first 512 cycles of each second. For the last 512 cycles they read 4'hF.
- R7: With adjust low, digits_o = {hour tens, hour ones, minute tens, minute ones, second tens, second ones}, 4 bits each, from bit 23 down to bit 0, with no blanking.
- R8: When minutes are 59 and seconds are 53, 55 or 57, tone_o follows a square wave that toggles on every reference edge (512 Hz). It is 0 at all times outside both chime windows.
- R9: At minute 59, second 59, tone_o equals the 1024 Hz reference itself: high while the clock is high and low while the clock is low.
- R10: While rst_ni is low, all six digits are 0 and tone_o is 0.
- R11: adj_en_i, sel_i and inc_i pass through a two-flop synchronizer. A rising edge of sel_i or inc_i held high for many cycles acts exactly once, on the third reference edge after it is sampled high. The adjust level seen by the display follows adj_en_i one edge after sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 1024 Hz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adj_en_i | input | 1 | Adjust mode level (asynchronous) |
| sel_i | input | 1 | Target-field toggle button (asynchronous) |
| inc_i | input | 1 | Increment button (asynchronous) |
| digits_o | output | 24 | Six BCD digits, hour tens at the top, blanked as 4'hF while blinking |
| tone_o | output | 1 | Chime tone |

## Verification
On every cycle, the assertions check these properties:
- seconds hold between ticks;
- seconds and hours wrap correctly;
- the target field is frozen outside adjust mode;
- one increment press gives a single pulse;
- blanking appears in the low blink half;
- digits pass through unchanged outside adjust mode;
- the tone is silent outside the last seconds of an hour.

The exact timing of the three input synchronizers, a manual rollover that does not carry, the 1024 Hz pitch at second 59, and the full run up to midnight with its rollover can only be shown by the bench. The bench does this by comparing the ports with a cycle model under directed settings and random button activity.

// File: rtl/clk_core_pkg.sv
package clk_core_pkg;

  typedef struct packed {
    logic [3:0] hi;
    logic [3:0] lo;
  } bcd_pair_t;

  typedef enum logic {
    SEL_MIN = 1'b0,
    SEL_HR  = 1'b1
  } field_sel_e;

  localparam logic [3:0] BLANK_DIGIT = 4'hF;
  localparam int CHIME_MIN = 59;
  localparam int CHIME_HI_SEC = 59;

  function automatic logic is_pair(bcd_pair_t p, int v);
    return (p.hi == 4'(v / 10)) && (p.lo == 4'(v % 10));
  endfunction

endpackage

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int DIV = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sec_tick_o,
  output logic blink_on_o,
  output logic tone_lo_o
);
  localparam int CW = $clog2(DIV);

  logic [CW-1:0] cnt_q;
  logic          tone_q;

  assign sec_tick_o = (cnt_q == CW'(DIV - 1));
  assign blink_on_o = (cnt_q < CW'(DIV / 2));
  assign tone_lo_o  = tone_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tone_q <= 1'b0;
    end else begin
      cnt_q  <= sec_tick_o ? '0 : cnt_q + 1'b1;
      tone_q <= ~tone_q;
    end
  end
endmodule

// File: rtl/in_sync.sv
module in_sync #(
  parameter int             W         = 3,
  parameter int             STAGES    = 2,
  parameter logic [W-1:0]   EDGE_MASK = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], in_i[i]};
    end

    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= chain_q[STAGES-1];
      end
      assign out_o[i] = chain_q[STAGES-1] & ~prev_q;
    end else begin : g_lvl
      assign out_o[i] = chain_q[STAGES-1];
    end
  end
endmodule

// File: rtl/bcd_field.sv
module bcd_field
  import clk_core_pkg::*;
#(
  parameter int LAST = 59
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      step_i,
  output bcd_pair_t val_o,
  output logic      wrap_o
);
  localparam logic [3:0] LAST_HI = 4'(LAST / 10);
  localparam logic [3:0] LAST_LO = 4'(LAST % 10);

  bcd_pair_t q;
  logic      at_last;

  assign at_last = (q.hi == LAST_HI) && (q.lo == LAST_LO);
  assign wrap_o  = step_i && at_last;
  assign val_o   = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (step_i) begin
      if (at_last) begin
        q <= '0;
      end else if (q.lo == 4'd9) begin
        q.lo <= 4'd0;
        q.hi <= q.hi + 4'd1;
      end else begin
        q.lo <= q.lo + 4'd1;
      end
    end
  end
endmodule

// File: rtl/chime_gen.sv
module chime_gen
  import clk_core_pkg::*;
(
  input  logic      clk_i,
  input  bcd_pair_t mn_i,
  input  bcd_pair_t sc_i,
  input  logic      tone_lo_i,
  output logic      tone_o
);
  logic last_min, win_lo, win_hi;

  assign last_min = is_pair(mn_i, CHIME_MIN);
  assign win_lo   = last_min && (is_pair(sc_i, 53) || is_pair(sc_i, 55) || is_pair(sc_i, 57));
  assign win_hi   = last_min && is_pair(sc_i, CHIME_HI_SEC);
  // high pitch is the reference itself, gated by a registered window
  assign tone_o   = (win_lo && tone_lo_i) || (win_hi && clk_i);
endmodule

// File: rtl/clock_core.sv
module clock_core
  import clk_core_pkg::*;
#(
  parameter int DIV         = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        adj_en_i,
  input  logic        sel_i,
  input  logic        inc_i,
  output logic [23:0] digits_o,
  output logic        tone_o
);
  logic [2:0] btn_sync;
  logic       adj_q, sel_rise, inc_rise;
  logic       sec_tick, blink_on, tone_lo;
  logic       sec_wrap, min_wrap, hr_wrap;
  logic       min_man, hr_man, min_step, hr_step;
  field_sel_e field_sel_q;
  bcd_pair_t  hr_val, mn_val, sc_val, hr_disp, mn_disp;

  in_sync #(
    .W        (3),
    .STAGES   (SYNC_STAGES),
    .EDGE_MASK(3'b110)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({inc_i, sel_i, adj_en_i}),
    .out_o (btn_sync)
  );
  assign adj_q    = btn_sync[0];
  assign sel_rise = btn_sync[1];
  assign inc_rise = btn_sync[2];

  tick_gen #(.DIV(DIV)) i_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sec_tick_o(sec_tick),
    .blink_on_o(blink_on),
    .tone_lo_o (tone_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                field_sel_q <= SEL_MIN;
    else if (adj_q && sel_rise) field_sel_q <= (field_sel_q == SEL_MIN) ? SEL_HR : SEL_MIN;
  end

  assign min_man  = adj_q && (field_sel_q == SEL_MIN);
  assign hr_man   = adj_q && (field_sel_q == SEL_HR);
  assign min_step = min_man ? inc_rise : sec_wrap;
  // manual rollover of minutes never carries
  assign hr_step  = hr_man ? inc_rise : (min_wrap && !min_man);

  bcd_field #(.LAST(59)) i_sec (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(sec_tick), .val_o(sc_val), .wrap_o(sec_wrap)
  );
  bcd_field #(.LAST(59)) i_min (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(min_step), .val_o(mn_val), .wrap_o(min_wrap)
  );
  bcd_field #(.LAST(23)) i_hr (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(hr_step), .val_o(hr_val), .wrap_o(hr_wrap)
  );

  always_comb begin
    hr_disp = hr_val;
    mn_disp = mn_val;
    if (!blink_on) begin
      if (hr_man)  hr_disp = {BLANK_DIGIT, BLANK_DIGIT};
      if (min_man) mn_disp = {BLANK_DIGIT, BLANK_DIGIT};
    end
  end

  assign digits_o = {hr_disp, mn_disp, sc_val};

  chime_gen i_chime (
    .clk_i    (clk_i),
    .mn_i     (mn_val),
    .sc_i     (sc_val),
    .tone_lo_i(tone_lo),
    .tone_o   (tone_o)
  );

  logic unused_hr_wrap;
  assign unused_hr_wrap = hr_wrap;
endmodule

// File: rtl/clock_core_chk.sv
module clock_core_chk
  import clk_core_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        adj_q,
  input logic        inc_rise,
  input logic        sec_tick,
  input logic        blink_on,
  input logic        hr_step,
  input field_sel_e  field_sel_q,
  input bcd_pair_t   hr_val,
  input bcd_pair_t   mn_val,
  input bcd_pair_t   sc_val,
  input logic [23:0] digits_o,
  input logic        tone_o
);
  assert_sec_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_tick |=> $stable(sc_val));

  assert_sec_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick && sc_val == 8'h59) |=> (sc_val == 8'h00));

  assert_hr_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hr_step && hr_val == 8'h23) |=> (hr_val == 8'h00));

  assert_sel_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adj_q |=> $stable(field_sel_q));

  assert_blank_hr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adj_q && field_sel_q == SEL_HR && !blink_on) |-> (digits_o[23:16] == 8'hFF));

  assert_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adj_q |-> (digits_o == {hr_val, mn_val, sc_val}));

  assert_chime_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mn_val == 8'h59 && sc_val.hi == 4'd5) |-> !tone_o);

  assert_inc_once_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_rise |=> !inc_rise);

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_R10: assert ({hr_val, mn_val, sc_val} == 24'h0);
  end
endmodule

bind clock_core clock_core_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .adj_q      (adj_q),
  .inc_rise   (inc_rise),
  .sec_tick   (sec_tick),
  .blink_on   (blink_on),
  .hr_step    (hr_step),
  .field_sel_q(field_sel_q),
  .hr_val     (hr_val),
  .mn_val     (mn_val),
  .sc_val     (sc_val),
  .digits_o   (digits_o),
  .tone_o     (tone_o)
);

// File: tb/test_clock_core.sv
module test_clock_core;
  localparam int DIV = 1024;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        adj = 1'b0, sel = 1'b0, inc = 1'b0;
  logic [23:0] dig;
  logic        tone;

  int checks = 0, fails = 0;

  clock_core i_clock_core (
    .clk_i(clk), .rst_ni(rst_n), .adj_en_i(adj), .sel_i(sel), .inc_i(inc),
    .digits_o(dig), .tone_o(tone)
  );

  // cycle model built from the requirements
  int m_div, m_sec, m_min, m_hr;
  bit m_fsel, m_tone;
  bit [3:0] ha, hs, hi;
  int n_edges;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div = 0; m_sec = 0; m_min = 0; m_hr = 0; m_fsel = 0; m_tone = 0;
      ha = 0; hs = 0; hi = 0; n_edges = 0;
    end else begin
      bit tick, adj_eff, r_inc, r_sel, min_man, hr_man, min_step, hr_step, min_carry, sec_wrap;
      adj_eff = ha[1];
      r_inc = hi[1] & ~hi[2];
      r_sel = hs[1] & ~hs[2];
      tick = (m_div == DIV - 1);
      m_div = tick ? 0 : m_div + 1;
      sec_wrap = tick && (m_sec == 59);
      if (tick) m_sec = (m_sec + 1) % 60;
      min_man = adj_eff && !m_fsel;
      hr_man = adj_eff && m_fsel;
      min_step = min_man ? r_inc : sec_wrap;
      min_carry = min_step && (m_min == 59) && !min_man;
      if (min_step) m_min = (m_min + 1) % 60;
      hr_step = hr_man ? r_inc : min_carry;
      if (hr_step) m_hr = (m_hr + 1) % 24;
      if (adj_eff && r_sel) m_fsel = !m_fsel;
      m_tone = !m_tone;
      ha = {ha[2:0], adj}; hs = {hs[2:0], sel}; hi = {hi[2:0], inc};
      n_edges++;
    end
  end

  function automatic logic [7:0] bcd2(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [23:0] exp_digits();
    logic [7:0] h, m;
    h = bcd2(m_hr);
    m = bcd2(m_min);
    if (ha[1] && !(m_div < DIV / 2)) begin
      if (m_fsel) h = 8'hFF;
      else        m = 8'hFF;
    end
    return {h, m, bcd2(m_sec)};
  endfunction

  function automatic bit win_lo();
    return m_min == 59 && (m_sec == 53 || m_sec == 55 || m_sec == 57);
  endfunction

  function automatic bit win_hi();
    return m_min == 59 && m_sec == 59;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison, clock high and clock low
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk(ha[1] ? "R6 blink" : "R7 pass", int'(dig), int'(exp_digits()));
      if (win_hi()) chk("R9 tone high phase", int'(tone), 1);
      else          chk("R8 tone", int'(tone), win_lo() ? int'(m_tone) : 0);
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (win_hi()) chk("R9 tone low phase", int'(tone), 0);
      else          chk("R8 tone", int'(tone), win_lo() ? int'(m_tone) : 0);
    end
  end

  task automatic press_inc(int hold);
    @(negedge clk) inc = 1'b1;
    repeat (hold) @(negedge clk);
    inc = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic press_sel();
    @(negedge clk) sel = 1'b1;
    repeat (3) @(negedge clk);
    sel = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R10 reset digits", int'(dig), 0);
    chk("R10 reset tone", int'(tone), 0);
    rst_n = 1'b1;

    // R1: second boundary
    while (n_edges < DIV - 1) @(negedge clk);
    chk("R1 before tick", int'(dig[7:0]), 8'h00);
    @(negedge clk);
    chk("R1 after tick", int'(dig[7:0]), 8'h01);

    // set 23:59 by hand; first press held long (R11)
    adj = 1'b1;
    repeat (4) @(negedge clk);
    press_inc(20);
    repeat (58) press_inc(2);
    press_sel();
    repeat (23) press_inc(2);
    adj = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5/R11 set 23:59", int'(dig[23:8]), 16'h2359);

    // chime windows and midnight rollover
    while (m_sec != 54) @(negedge clk);
    chk("R8 quiet at :54", int'(tone), 0);
    while (m_sec != 59) @(negedge clk);
    @(posedge clk); #1;
    chk("R9 high phase", int'(tone), 1);
    @(negedge clk); #1;
    chk("R9 low phase", int'(tone), 0);
    while (m_sec != 0) @(negedge clk);
    chk("R2/R3 midnight", int'(dig), 24'h000000);

    // R4: select ignored outside adjust; hours stay target
    press_sel();
    adj = 1'b1;
    repeat (4) @(negedge clk);
    while (m_div < DIV / 2 + 8) @(negedge clk);
    chk("R4/R6 hour blank", int'(dig[23:16]), 8'hFF);
    chk("R6 minute shown", int'(dig[15:8]), 8'h00);
    press_inc(2);
    adj = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 hour step", int'(dig[23:8]), 16'h0100);
    adj = 1'b1;
    repeat (4) @(negedge clk);
    repeat (23) press_inc(2);
    adj = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 manual hour wrap", int'(dig[23:8]), 16'h0000);

    // R5: manual minute wrap gives no hour carry
    adj = 1'b1;
    repeat (4) @(negedge clk);
    press_sel();
    repeat (60) press_inc(2);
    adj = 1'b0;
    repeat (4) @(negedge clk);
    chk("R5 minute wrap no carry", int'(dig[23:8]), 16'h0000);

    // random button activity
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if ($urandom % 300 == 0) adj = ~adj;
      if ($urandom % 6 == 0) sel = ($urandom % 8 == 0);
      if ($urandom % 3 == 0) inc = ($urandom % 2 == 0);
    end
    adj = 1'b0; sel = 1'b0; inc = 1'b0;

    @(negedge clk) rst_n = 1'b0;
    #1;
    chk("R10 reset again", int'(dig), 0);
    chk("R10 reset tone again", int'(tone), 0);
    finish_run();
  end
endmodule